// File: doc/BRIEF.md
# Pointer-Indirect Byte Store Address Unit

This unit sits in the execute path of a small 8-bit processor core. It takes one 16-bit store opcode that names a pointer held in a 16-bit register, Z. It works out the data-space byte address, fetches the source byte through a register-file read select, and drives a one-cycle memory write strobe. Where the form changes Z, it also presents the new pointer value with its write-back enables. The opcode space covers four forms: pointer plus a 6-bit displacement (with zero displacement as the plain form), post-increment, and pre-decrement. Status flags are never touched, and no flag output exists.

Pointer arithmetic width is chosen by the `mode` pin. It can be 8 bits, where only the low pointer byte moves. It can be 16 bits. It can be 24 bits, where an 8-bit extension register sits above Z and takes the carry or borrow. The `fast` pin selects a core timing in which the plain and post-increment forms finish in one cycle. Without it, every form takes two.

Opcodes arrive on a valid/ready input. An opcode is accepted on a rising edge where `in_valid` and `in_ready` are both high. Opcode, `z_cur`, `ext_cur`, `mode`, `fast` and `rf_rdata` are sampled on that edge. `in_ready` falls for exactly one cycle after a two-cycle form is accepted, and the sender must hold or withdraw its opcode during that cycle. The results are plain strobes with no back-pressure.

Top module: `ptr_store_unit`

## Requirements
- R1: Only these opcodes are recognised: `(op & 16'hFE0F) == 16'h9201` (post-increment), `(op & 16'hFE0F) == 16'h9202` (pre-decrement), and `(op & 16'hD208) == 16'h8200` (displacement). Any other opcode is accepted but gives no `st_we`, no `z_we`, no `ext_we` and no `pc_adv`.
- R2: The displacement form stores at pointer + q, where q = {op[13], op[11:10], op[2:0]} (0..63), and raises no `z_we`. q = 0 is the plain form.
- R3: The post-increment form stores at the pointer and presents pointer + 1 on `z_new` with `z_we` high.
- R4: The pre-decrement form stores at pointer − 1 and presents that same decremented value on `z_new` with `z_we` high.
- R5: With `mode` = 0, arithmetic wraps in 8 bits on Z[7:0]. `st_addr[23:8]` is zero, `z_new[15:8]` equals the sampled Z[15:8], and `ext_we` stays low.
- R6: With `mode` = 1 (and 3), arithmetic wraps in 16 bits on Z. `st_addr[23:16]` is zero and `ext_we` stays low.
- R7: With `mode` = 2, arithmetic uses the 24-bit value {ext_cur, Z} and wraps in 24 bits. Every pointer update raises `ext_we` together with `z_we`, with `ext_new` holding bits 23:16.
- R8: `rf_sel` equals op[8:4]. `st_data` is the `rf_rdata` byte sampled when the opcode is accepted.
- R9: With `fast` = 0, `st_we` pulses on the second edge after acceptance for every form. With `fast` = 1, the plain and post-increment forms pulse on the first edge, and pre-decrement and nonzero displacement pulse on the second.
- R10: `in_ready` is low for exactly the one cycle following acceptance of a two-cycle form and high otherwise, including out of reset.
- R11: Post-increment or pre-decrement with source r30 or r31 raises `undef_combo` with the strobe. The store still uses the sampled source byte, and the pointer update still takes place.
- R12: `pc_adv` pulses for one cycle together with each `st_we`. It never pulses otherwise, and reset leaves all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode present |
| in_ready | output | 1 | Unit can take an opcode this cycle |
| in_opcode | input | 16 | Store opcode |
| z_cur | input | 16 | Current pointer value |
| ext_cur | input | 8 | Current pointer extension byte |
| mode | input | 2 | Pointer width: 0 = 8-bit, 1/3 = 16-bit, 2 = 24-bit |
| fast | input | 1 | Single-cycle timing for plain and post-increment |
| rf_sel | output | 5 | Register-file read index |
| rf_rdata | input | 8 | Register-file byte at `rf_sel` |
| st_we | output | 1 | Data-space write strobe |
| st_addr | output | 24 | Data-space byte address |
| st_data | output | 8 | Byte to write |
| z_we | output | 1 | Pointer write-back enable |
| z_new | output | 16 | New pointer value |
| ext_we | output | 1 | Extension-byte write-back enable |
| ext_new | output | 8 | New extension byte |
| pc_adv | output | 1 | Advance the PC by one word |
| undef_combo | output | 1 | Undefined source/pointer combination |

## Verification
A wrong internal state shows at the ports in one of two ways: a misdecoded form, or a corrupted held result. Either gives a wrong `st_addr`, `z_new` or write-enable on the very strobe of that opcode, so each error appears within two cycles of acceptance. A stuck wait state shows sooner. `in_ready` stays low, or the strobe lands one edge early or late, on the first two-cycle opcode. The sweeps cover every source index for each updating form and every displacement, in all three widths and both timings, with pointers placed on 8-, 16- and 24-bit wrap boundaries.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  localparam int OP_W   = 16;
  localparam int PTR_W  = 16;
  localparam int EXT_W  = 8;
  localparam int FULL_W = PTR_W + EXT_W;
  localparam int DAT_W  = 8;
  localparam int RIX_W  = 5;
  localparam int DSP_W  = 6;

  typedef enum logic [1:0] {
    FM_PLAIN   = 2'd0,
    FM_POSTINC = 2'd1,
    FM_PREDEC  = 2'd2,
    FM_DISP    = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    AM_BYTE   = 2'd0,
    AM_LINEAR = 2'd1,
    AM_WIDE   = 2'd2,
    AM_SPARE  = 2'd3
  } amode_e;

  typedef struct packed {
    logic [FULL_W-1:0] addr;
    logic [DAT_W-1:0]  data;
    logic              ptr_upd;
    logic              ext_upd;
    logic [PTR_W-1:0]  z_nx;
    logic [EXT_W-1:0]  e_nx;
    logic              undef;
  } result_t;
endpackage

// File: rtl/pstore_decode.sv
module pstore_decode
  import pstore_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int RIW = RIX_W,
  parameter int QW  = DSP_W
) (
  input  logic [OPW-1:0] op,
  input  logic           fast,
  output logic           hit,
  output form_e          form,
  output logic [RIW-1:0] ridx,
  output logic [QW-1:0]  q,
  output logic           undef,
  output logic           long_op
);
  logic is_post, is_pre, is_disp;

  assign is_post = (op & 16'hFE0F) == 16'h9201;
  assign is_pre  = (op & 16'hFE0F) == 16'h9202;
  assign is_disp = (op & 16'hD208) == 16'h8200;

  assign q    = {op[13], op[11:10], op[2:0]};
  assign ridx = op[8:4];
  assign hit  = is_post | is_pre | is_disp;

  always_comb begin
    if (is_post)      form = FM_POSTINC;
    else if (is_pre)  form = FM_PREDEC;
    else if (q == '0) form = FM_PLAIN;
    else              form = FM_DISP;
  end

  // r30/r31 are the two halves of the pointer itself
  assign undef   = (is_post | is_pre) && (ridx[RIW-1:1] == '1);
  assign long_op = hit && (!fast || form == FM_PREDEC || form == FM_DISP);
endmodule

// File: rtl/pstore_agen.sv
module pstore_agen
  import pstore_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int EW = EXT_W,
  parameter int QW = DSP_W,
  parameter int DW = DAT_W
) (
  input  form_e         form,
  input  logic [QW-1:0] q,
  input  logic [PW-1:0] z,
  input  logic [EW-1:0] ext,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] rdata,
  input  logic          undef,
  output result_t       res
);
  localparam int FW = PW + EW;
  localparam int BW = 8;

  logic [FW-1:0] base, a_off, p_off, a_sum, p_sum, mask;

  always_comb begin
    case (amode_e'(mode))
      AM_BYTE: begin
        base = {{(FW-BW){1'b0}}, z[BW-1:0]};
        mask = {{(FW-BW){1'b0}}, {BW{1'b1}}};
      end
      AM_WIDE: begin
        base = {ext, z};
        mask = '1;
      end
      default: begin
        base = {{EW{1'b0}}, z};
        mask = {{EW{1'b0}}, {PW{1'b1}}};
      end
    endcase
  end

  always_comb begin
    case (form)
      FM_POSTINC: begin a_off = '0; p_off = FW'(1); end
      FM_PREDEC:  begin a_off = '1; p_off = '1;     end
      default:    begin a_off = FW'(q); p_off = '0; end
    endcase
  end

  assign a_sum = base + a_off;
  assign p_sum = base + p_off;

  always_comb begin
    res.addr    = a_sum & mask;
    res.data    = rdata;
    res.ptr_upd = (form == FM_POSTINC) || (form == FM_PREDEC);
    res.ext_upd = res.ptr_upd && (amode_e'(mode) == AM_WIDE);
    res.z_nx    = (amode_e'(mode) == AM_BYTE) ? {z[PW-1:BW], p_sum[BW-1:0]}
                                              : p_sum[PW-1:0];
    res.e_nx    = p_sum[FW-1:PW];
    res.undef   = undef;
  end
endmodule

// File: rtl/pstore_seq.sv
module pstore_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic hit,
  input  logic long_op,
  output logic in_ready,
  output logic load,
  output logic fire
);
  logic wait_q;

  assign in_ready = !wait_q;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      wait_q <= load && hit && long_op;
      fire   <= (load && hit && !long_op) || wait_q;
    end
  end
endmodule

// File: rtl/ptr_store_unit.sv
module ptr_store_unit
  import pstore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [PTR_W-1:0]  z_cur,
  input  logic [EXT_W-1:0]  ext_cur,
  input  logic [1:0]        mode,
  input  logic              fast,
  output logic [RIX_W-1:0]  rf_sel,
  input  logic [DAT_W-1:0]  rf_rdata,
  output logic              st_we,
  output logic [FULL_W-1:0] st_addr,
  output logic [DAT_W-1:0]  st_data,
  output logic              z_we,
  output logic [PTR_W-1:0]  z_new,
  output logic              ext_we,
  output logic [EXT_W-1:0]  ext_new,
  output logic              pc_adv,
  output logic              undef_combo
);
  logic             hit, undef, long_op, load, fire;
  form_e            form;
  logic [DSP_W-1:0] q;
  result_t          res_d, res_q;

  pstore_decode u_dec (
    .op(in_opcode), .fast(fast), .hit(hit), .form(form),
    .ridx(rf_sel), .q(q), .undef(undef), .long_op(long_op)
  );

  pstore_agen u_agen (
    .form(form), .q(q), .z(z_cur), .ext(ext_cur), .mode(mode),
    .rdata(rf_rdata), .undef(undef), .res(res_d)
  );

  pstore_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit),
    .long_op(long_op), .in_ready(in_ready), .load(load), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    res_q <= '0;
    else if (load) res_q <= res_d;
  end

  assign st_we       = fire;
  assign pc_adv      = fire;
  assign st_addr     = res_q.addr;
  assign st_data     = res_q.data;
  assign z_we        = fire && res_q.ptr_upd;
  assign z_new       = res_q.z_nx;
  assign ext_we      = fire && res_q.ext_upd;
  assign ext_new     = res_q.e_nx;
  assign undef_combo = fire && res_q.undef;
endmodule

// File: rtl/pstore_chk.sv
module pstore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        st_we,
  input logic        z_we,
  input logic        ext_we,
  input logic        pc_adv,
  input logic        undef_combo,
  input logic [1:0]  mode,
  input logic [23:0] st_addr
);
  a_r10_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  a_r9_stall_ends_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> st_we);

  a_r12_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> ($past(in_valid && in_ready) || !$past(in_ready)));

  a_r3_ptr_we_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    z_we |-> (st_we && pc_adv));

  a_r7_ext_we_with_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> z_we);

  a_r11_undef_only_updating: assert property (@(posedge clk) disable iff (!rst_n)
    undef_combo |-> z_we);

  a_r5_byte_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && mode == 2'd0 && $stable(mode)) |-> (st_addr[23:8] == 16'h0));
endmodule

bind ptr_store_unit pstore_chk u_chk (.*);

// File: tb/tb_ptr_store_unit.sv
module tb_ptr_store_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_opcode = '0;
  logic [15:0] z_cur = '0;
  logic [7:0]  ext_cur = '0;
  logic [1:0]  mode = 2'd1;
  logic        fast = 1'b0;
  logic [4:0]  rf_sel;
  logic [7:0]  rf_rdata;
  logic        st_we, z_we, ext_we, pc_adv, undef_combo;
  logic [23:0] st_addr;
  logic [15:0] z_new;
  logic [7:0]  ext_new;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rf_model(input int r);
    return 8'((r * 37 + 5) & 255);
  endfunction

  assign rf_rdata = rf_model(int'(rf_sel));

  ptr_store_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .z_cur(z_cur), .ext_cur(ext_cur), .mode(mode),
    .fast(fast), .rf_sel(rf_sel), .rf_rdata(rf_rdata), .st_we(st_we),
    .st_addr(st_addr), .st_data(st_data), .z_we(z_we), .z_new(z_new),
    .ext_we(ext_we), .ext_new(ext_new), .pc_adv(pc_adv),
    .undef_combo(undef_combo)
  );

  logic [7:0] st_data;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (mode=%0d fast=%0d op=%h)",
               tag, act, exp, mode, fast, in_opcode);
    end
  endtask

  function automatic logic [15:0] mk_op(input int fm, input int r, input int q);
    logic [15:0] o;
    case (fm)
      1: o = 16'h9201;
      2: o = 16'h9202;
      default: o = 16'h8200 | 16'((q >> 5 & 1) << 13) | 16'((q >> 3 & 3) << 10)
                 | 16'(q & 7);
    endcase
    return o | 16'((r & 31) << 4);
  endfunction

  // fm: 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement
  task automatic do_store(input int fm, input int r, input int q,
                          input logic [15:0] z, input logic [7:0] e);
    int mask, base, aoff, poff, ea, pn, ez;
    bit lng, upd, und;
    mask = (mode == 2'd0) ? 'hFF : (mode == 2'd2) ? 'hFFFFFF : 'hFFFF;
    base = (mode == 2'd0) ? int'(z[7:0]) : (mode == 2'd2) ? int'({e, z}) : int'(z);
    aoff = (fm == 2) ? -1 : (fm == 1) ? 0 : q;
    poff = (fm == 2) ? -1 : (fm == 1) ? 1 : 0;
    ea   = (base + aoff) & mask;
    pn   = (base + poff) & mask;
    ez   = (mode == 2'd0) ? ((int'(z) & 'hFF00) | (pn & 'hFF)) : (pn & 'hFFFF);
    lng  = !fast || fm == 2 || (fm == 3 && q != 0);
    upd  = (fm == 1) || (fm == 2);
    und  = upd && r >= 30;

    chk("R10 ready before issue", int'(in_ready), 1);
    in_opcode = mk_op(fm, r, q);
    z_cur = z; ext_cur = e; in_valid = 1'b1;
    #1 chk("R8 rf_sel index", int'(rf_sel), r);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (lng) begin
      chk("R9 no early strobe", int'(st_we), 0);
      chk("R10 ready low in wait", int'(in_ready), 0);
      @(negedge clk);
    end
    chk("R1 store strobe", int'(st_we), 1);
    chk("R12 pc advance", int'(pc_adv), 1);
    chk("R10 ready back", int'(in_ready), 1);
    if (fm == 1)      chk("R3 post-inc address", int'(st_addr), ea);
    else if (fm == 2) chk("R4 pre-dec address", int'(st_addr), ea);
    else              chk("R2 displacement address", int'(st_addr), ea);
    if (mode == 2'd0) chk("R5 byte mode high addr", int'(st_addr[23:8]), 0);
    if (mode == 2'd1) chk("R6 linear high addr", int'(st_addr[23:16]), 0);
    chk("R8 store data", int'(st_data), int'(rf_model(r)));
    chk("R11 undefined flag", int'(undef_combo), int'(und));
    chk("R2 pointer write enable", int'(z_we), int'(upd));
    if (upd) begin
      if (mode == 2'd0) chk("R5 byte mode pointer", int'(z_new), ez);
      else if (fm == 1) chk("R3 incremented pointer", int'(z_new), ez);
      else              chk("R4 decremented pointer", int'(z_new), ez);
    end
    chk("R7 ext write enable", int'(ext_we), int'(upd && mode == 2'd2));
    if (upd && mode == 2'd2) chk("R7 ext new byte", int'(ext_new), (pn >> 16) & 'hFF);
    @(negedge clk);
    chk("R12 single pulse", int'(st_we) + int'(pc_adv), 0);
  endtask

  task automatic do_junk(input logic [15:0] op);
    in_opcode = op; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 ignored opcode ready", int'(in_ready), 1);
    chk("R1 ignored opcode strobe", int'(st_we) + int'(z_we) + int'(ext_we) + int'(pc_adv), 0);
    @(negedge clk);
    chk("R1 ignored opcode late strobe", int'(st_we) + int'(z_we) + int'(pc_adv), 0);
  endtask

  initial begin
    logic [15:0] zl [4];
    logic [7:0]  el [4];
    zl[0] = 16'h0000; zl[1] = 16'h12FF; zl[2] = 16'hFFFF; zl[3] = 16'h3480;
    el[0] = 8'h00;    el[1] = 8'h5A;    el[2] = 8'hFF;    el[3] = 8'h01;
    repeat (3) @(negedge clk);
    chk("R12 reset strobe", int'(st_we) + int'(z_we) + int'(ext_we) + int'(pc_adv) + int'(undef_combo), 0);
    chk("R10 reset ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      for (int f = 0; f < 2; f++) begin
        mode = 2'(m); fast = 1'(f);
        for (int fm = 1; fm <= 2; fm++)
          for (int r = 0; r < 32; r++)
            for (int zi = 0; zi < 4; zi++)
              do_store(fm, r, 0, zl[zi], el[zi]);
        for (int q = 0; q < 64; q++)
          do_store((q == 0) ? 0 : 3, (q * 5) % 32, q, zl[q % 4], el[q % 4]);
        do_junk(16'h9203);
        do_junk(16'h0000);
        do_junk(16'h8000);
        do_junk(16'h920F);
        do_junk(16'h9200);
      end
    end
    mode = 2'd3; fast = 1'b1;
    do_store(1, 7, 0, 16'hFFFF, 8'h33);
    do_store(3, 2, 40, 16'hFFF0, 8'h33);
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule